// File: doc/BRIEF.md
# Shadowed Calendar Register Port

This block puts a set of calendar registers and a small scratch RAM behind a byte-wide, SRAM-like host port with active-low chip enable, output enable and write enable. Every port input is sampled on a system clock. The eight highest addresses of a 17-bit space select the calendar registers. Every lower address goes to the scratch RAM, and its upper bits alias. Read data is produced combinationally from the address and the stored state. The bidirectional data bus is split into an input byte, an output byte and an output enable, so that the pad ring can drive it.

The running counters live outside this block. The block receives their value on a packed bus together with a one-second tick. It keeps its own host-visible copy of every time field and refreshes that copy after each tick. Two control bits can stop the refresh. One freezes the copy so that a consistent snapshot can be read. The other lets the host stage new time values. When the host clears it, the block emits a one-cycle load strobe that carries the staged values to the counters.

Inside the calendar registers, bits that hold no time digit act as plain storage. Some of those bits also drive outputs: an oscillator-stop control and a frequency-test enable. One bit reflects the battery health input and cannot be written.

Top module: `rtc_host_port`

## Requirements
- R1: The calendar registers occupy addresses 0x1FFF8 to 0x1FFFF, one per address, in this order: century, seconds, minutes, hours, weekday, day-of-month, month, year. Each register keeps what was written to it, independently of the others.
- R2: A read is selected when ce_n=0, oe_n=0 and we_n=1, and only then is dq_oe high. A write is selected when ce_n=0 and we_n=0, and it takes effect on the next rising clock edge.
- R3: Any address below 0x1FFF8 reads and writes a scratch RAM indexed by the low RAM_AW address bits. 0x1FFF7 therefore aliases RAM index 0x37.
- R4: When neither halt bit is set, every register's time bits show the live counter value from the second clock edge after sec_tick is sampled high, and still show the old value after the first edge. Live byte i sits at live_time[8i+7:8i]. The time-bit masks are: century 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day-of-month 0x3F, month 0x1F, year 0xFF.
- R5: While the read-halt bit (century bit 6) is 1, ticks do not change any host-visible time bits, and no load strobe is issued.
- R6: After the read-halt bit is cleared, the copies keep their frozen values until the next tick, which refreshes all eight registers together.
- R7: While the write-halt bit (century bit 7) is 1, ticks do not refresh the copies, and host writes set the time bits. The write that changes this bit from 1 to 0 raises load_stb for exactly one cycle, on the edge that takes the write. At the same time load_time carries the masked time bits of all eight registers, in the same byte order as live_time.
- R8: Bits outside the time masks store written data and survive tick refreshes.
- R9: Weekday bit 7 always reads as batt_ok, and writes to it have no effect.
- R10: osc_stop follows seconds bit 7, and ftest_en follows weekday bit 6.
- R11: While seconds is read, weekday bit 6 is 1 and seconds bit 7 is 0, dq_o bit 0 follows osc_512 combinationally. Otherwise it shows the stored bit.
- R12: After reset, all time copies and storage bits are 0, and load_stb, osc_stop and ftest_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 17 | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dq_i | input | 8 | Write data from the bus |
| dq_o | output | 8 | Read data to the bus |
| dq_oe | output | 1 | Drive enable for dq_o |
| live_time | input | 64 | Running counter value, byte i = register i |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| osc_512 | input | 1 | 512 Hz square wave from the counter core |
| batt_ok | input | 1 | Battery health, 1 = good |
| load_stb | output | 1 | One-cycle strobe that loads load_time into the counters |
| load_time | output | 64 | Staged time values, byte i = register i |
| osc_stop | output | 1 | Oscillator stop request |
| ftest_en | output | 1 | Frequency-test enable |

## Verification
Reads are combinational, so dq_o and dq_oe are sampled 1 ns after the bus is set up, with no clock edge in between. Writes, and the control outputs they drive, are checked at the falling edge that follows the capturing rising edge. A tick needs two rising edges: the bench checks the old value after the first, and the refreshed value only after the second. The load strobe is sampled at the falling edge right after the write that clears the staging bit, and again one cycle later to confirm that it has dropped.

// File: rtl/rtcif_pkg.sv
package rtcif_pkg;
    localparam int NREG   = 8;
    localparam int BYTE_W = 8;
    localparam int TIME_W = NREG * BYTE_W;

    localparam logic [2:0] IDX_CENT = 3'd0;
    localparam logic [2:0] IDX_SEC  = 3'd1;
    localparam logic [2:0] IDX_MIN  = 3'd2;
    localparam logic [2:0] IDX_HOUR = 3'd3;
    localparam logic [2:0] IDX_DAY  = 3'd4;
    localparam logic [2:0] IDX_DATE = 3'd5;
    localparam logic [2:0] IDX_MON  = 3'd6;
    localparam logic [2:0] IDX_YEAR = 3'd7;

    localparam int WR_HALT_BIT = 7;
    localparam int RD_HALT_BIT = 6;
    localparam int STOP_BIT    = 7;
    localparam int FTEST_BIT   = 6;
    localparam int BATT_BIT    = 7;

    typedef logic [NREG-1:0][BYTE_W-1:0] regbank_t;

    typedef struct packed {
        regbank_t cnt;    // host copy of time digits, already masked
        regbank_t spare;  // storage bits outside the digit fields
        logic     tick;   // delayed one-second tick
        logic     load;   // counter load strobe
    } shadow_t;

    // bits of each register that carry counter digits
    function automatic logic [BYTE_W-1:0] count_bits(input logic [2:0] idx);
        case (idx)
            IDX_CENT: return 8'h3F;
            IDX_SEC:  return 8'h7F;
            IDX_MIN:  return 8'h7F;
            IDX_HOUR: return 8'h3F;
            IDX_DAY:  return 8'h07;
            IDX_DATE: return 8'h3F;
            IDX_MON:  return 8'h1F;
            default:  return 8'hFF;
        endcase
    endfunction

    // bits that are driven from outside and never stored
    function automatic logic [BYTE_W-1:0] fixed_bits(input logic [2:0] idx);
        return (idx == IDX_DAY) ? 8'h80 : 8'h00;
    endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              rd_en,
    output logic              wr_en,
    output logic              clk_sel,
    output logic [2:0]        sel
);
    assign wr_en   = !ce_n && !we_n;
    assign rd_en   = !ce_n && !oe_n && we_n;
    assign clk_sel = &addr[ADDR_W-1:3];
    assign sel     = addr[2:0];
endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[a] <= wdata;
        end
    end

    assign rdata = mem[a];
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [TIME_W-1:0] live_time,
    input  logic              sec_tick,
    input  logic              batt_ok,
    input  logic              osc_512,
    output logic [BYTE_W-1:0] rd_data,
    output logic              load_stb,
    output logic [TIME_W-1:0] load_time,
    output logic              osc_stop,
    output logic              ftest_en
);
    shadow_t s_d, s_q;
    logic    halt;

    always_comb begin
        s_d      = s_q;
        s_d.tick = sec_tick;
        s_d.load = 1'b0;
        halt     = s_q.spare[IDX_CENT][WR_HALT_BIT] | s_q.spare[IDX_CENT][RD_HALT_BIT];
        if (s_q.tick && !halt) begin
            for (int i = 0; i < NREG; i++) begin
                s_d.cnt[i] = live_time[i*BYTE_W +: BYTE_W] & count_bits(3'(i));
            end
        end
        if (wr_en) begin
            s_d.cnt[sel]   = wdata & count_bits(sel);
            s_d.spare[sel] = wdata & ~count_bits(sel) & ~fixed_bits(sel);
            if (sel == IDX_CENT && s_q.spare[IDX_CENT][WR_HALT_BIT] && !wdata[WR_HALT_BIT]) begin
                s_d.load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_stb  = s_q.load;
    assign load_time = s_q.cnt;
    assign osc_stop  = s_q.spare[IDX_SEC][STOP_BIT];
    assign ftest_en  = s_q.spare[IDX_DAY][FTEST_BIT];

    always_comb begin
        rd_data = s_q.cnt[sel] | s_q.spare[sel];
        if (sel == IDX_DAY) begin
            rd_data[BATT_BIT] = batt_ok;
        end
        if (sel == IDX_SEC && ftest_en && !osc_stop) begin
            rd_data[0] = osc_512;
        end
    end

    // R7
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.load |=> !s_q.load);

    // R7
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.load |-> (!s_q.spare[IDX_CENT][WR_HALT_BIT] && $past(s_q.spare[IDX_CENT][WR_HALT_BIT])));

    // R5
    frozen_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> $stable(s_q.cnt));

    // R4
    refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tick && !halt && !wr_en) |=> (s_q.cnt[IDX_YEAR] == $past(live_time[TIME_W-1 -: BYTE_W])));
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtcif_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int RAM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [7:0]        dq_i,
    output logic [7:0]        dq_o,
    output logic              dq_oe,
    input  logic [63:0]       live_time,
    input  logic              sec_tick,
    input  logic              osc_512,
    input  logic              batt_ok,
    output logic              load_stb,
    output logic [63:0]       load_time,
    output logic              osc_stop,
    output logic              ftest_en
);
    logic              rd_en, wr_en, clk_sel;
    logic [2:0]        sel;
    logic              ram_we, reg_we;
    logic [BYTE_W-1:0] ram_rd, reg_rd;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_en(rd_en), .wr_en(wr_en), .clk_sel(clk_sel), .sel(sel)
    );

    assign ram_we = wr_en && !clk_sel;
    assign reg_we = wr_en && clk_sel;

    rtc_scratch_ram #(.AW(RAM_AW), .DW(BYTE_W)) u_ram (
        .clk(clk), .wr_en(ram_we), .a(addr[RAM_AW-1:0]),
        .wdata(dq_i), .rdata(ram_rd)
    );

    rtc_shadow_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(sel), .wdata(dq_i),
        .live_time(live_time), .sec_tick(sec_tick), .batt_ok(batt_ok),
        .osc_512(osc_512), .rd_data(reg_rd), .load_stb(load_stb),
        .load_time(load_time), .osc_stop(osc_stop), .ftest_en(ftest_en)
    );

    assign dq_o  = clk_sel ? reg_rd : ram_rd;
    assign dq_oe = rd_en;

    // R9
    batt_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && clk_sel && sel == IDX_DAY) |-> (dq_o[BATT_BIT] == batt_ok));

    // R10
    stop_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel == IDX_SEC) |=> (osc_stop == $past(dq_i[STOP_BIT])));
endmodule

// File: tb/sim_rtc_host_port.sv
module sim_rtc_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0]  dq_i = '0;
    logic [7:0]  dq_o;
    logic        dq_oe;
    logic [63:0] live = '0;
    logic        sec_tick = 1'b0, osc_512 = 1'b0, batt_ok = 1'b1;
    logic        load_stb, osc_stop, ftest_en;
    logic [63:0] load_time;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_cnt [8];
    logic [7:0] m_sp  [8];
    logic [7:0] m_ram [64];

    always #10 clk = ~clk;

    rtc_host_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .live_time(live), .sec_tick(sec_tick),
        .osc_512(osc_512), .batt_ok(batt_ok), .load_stb(load_stb), .load_time(load_time),
        .osc_stop(osc_stop), .ftest_en(ftest_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmask(input int k);
        case (k)
            0: return 8'h3F;  1: return 8'h7F;  2: return 8'h7F;  3: return 8'h3F;
            4: return 8'h07;  5: return 8'h3F;  6: return 8'h1F;  default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_reg(input int k);
        logic [7:0] v;
        v = m_cnt[k] | m_sp[k];
        if (k == 4) v[7] = batt_ok;
        if (k == 1 && m_sp[4][6] && !m_sp[1][7]) v[0] = osc_512;
        return v;
    endfunction

    function automatic logic [63:0] exp_load();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = m_cnt[k];
        return v;
    endfunction

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        int k;
        @(negedge clk);
        addr = a; dq_i = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        if (&a[16:3]) begin
            k = int'(a[2:0]);
            m_cnt[k] = d & cmask(k);
            m_sp[k]  = d & ~cmask(k) & ((k == 4) ? 8'h7F : 8'hFF);
        end else begin
            m_ram[a[5:0]] = d;
        end
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        d = dq_o; oe = dq_oe;
        #1;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic chk_reg(input string req, input int k);
        logic [7:0] d;
        logic oe;
        rd(17'h1FFF8 + 17'(k), d, oe);
        chk(req, {56'd0, d}, {56'd0, exp_reg(k)});
    endtask

    task automatic chk_all(input string req);
        for (int k = 0; k < 8; k++) chk_reg(req, k);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        if (!(m_sp[0][7] | m_sp[0][6]))
            for (int k = 0; k < 8; k++) m_cnt[k] = live[8*k +: 8] & cmask(k);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        for (int k = 0; k < 8; k++) begin m_cnt[k] = '0; m_sp[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        #1;
        chk("R12 load_stb", {63'd0, load_stb}, 64'd0);
        chk("R12 osc_stop", {63'd0, osc_stop}, 64'd0);
        chk("R12 ftest_en", {63'd0, ftest_en}, 64'd0);
        chk_all("R12 reg after reset");

        // R2 bus mode sweep over all enable combinations
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            addr = 17'h00003;
            ce_n = c[2]; oe_n = c[1]; we_n = c[0];
            #1;
            chk("R2 dq_oe", {63'd0, dq_oe}, {63'd0, (!c[2] && !c[1] && c[0])});
            #1;
            ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        end

        // R3 scratch RAM sweep
        for (int i = 0; i < 64; i++) wr(17'(i), 8'((i * 37 + 5) & 8'hFF));
        for (int i = 0; i < 64; i++) begin
            rd(17'(i), d, oe);
            chk("R3 ram", {56'd0, d}, {56'd0, m_ram[i]});
        end
        wr(17'h1FFF7, 8'hC3);
        rd(17'h00037, d, oe);
        chk("R3 alias 1FFF7", {56'd0, d}, 64'hC3);
        chk_reg("R3 year untouched", 7);

        // R1 register ordering: distinct patterns, halt bits kept clear
        for (int k = 0; k < 8; k++) wr(17'h1FFF8 + 17'(k), (k == 0) ? 8'h2A : 8'(8'h15 + 8'h22 * k));
        chk_all("R1 readback");
        wr(17'h1FFF9, 8'h00);
        wr(17'h1FFFC, 8'h00);

        // R4 refresh after tick, not earlier
        live = 64'h99_12_31_07_23_59_58_20;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        addr = 17'h1FFF9; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("R4 old after first edge", {56'd0, dq_o}, {56'd0, exp_reg(1)});
        #1;
        ce_n = 1'b1; oe_n = 1'b1;
        for (int k = 0; k < 8; k++) m_cnt[k] = live[8*k +: 8] & cmask(k);
        chk_all("R4 refreshed");
        live = 64'hFF_FF_FF_FF_FF_FF_FF_FF;
        tick();
        chk_all("R4 masked live");

        // R8 spare bits store and survive refresh
        wr(17'h1FFFA, 8'hFF);
        wr(17'h1FFFB, 8'hFF);
        wr(17'h1FFFC, 8'h38);
        wr(17'h1FFFD, 8'hFF);
        wr(17'h1FFFE, 8'hFF);
        chk_all("R8 after writes");
        live = 64'h05_04_03_02_01_00_12_34;
        tick();
        chk_all("R8 after refresh");

        // R9 battery flag
        batt_ok = 1'b0;
        wr(17'h1FFFC, 8'h80);
        chk_reg("R9 flag low", 4);
        batt_ok = 1'b1;
        chk_reg("R9 flag high", 4);

        // R10 control outputs
        wr(17'h1FFF9, 8'h80);
        #1 chk("R10 osc_stop set", {63'd0, osc_stop}, 64'd1);
        wr(17'h1FFFC, 8'h40);
        #1 chk("R10 ftest_en set", {63'd0, ftest_en}, 64'd1);

        // R11 frequency test while stopped: stored bit shown
        @(negedge clk);
        addr = 17'h1FFF9; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        osc_512 = 1'b1; #1 chk("R11 stopped", {56'd0, dq_o}, {56'd0, exp_reg(1)});
        #1 ce_n = 1'b1; oe_n = 1'b1;
        wr(17'h1FFF9, 8'h00);
        #1 chk("R10 osc_stop clear", {63'd0, osc_stop}, 64'd0);
        @(negedge clk);
        addr = 17'h1FFF9; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        for (int t = 0; t < 6; t++) begin
            osc_512 = t[0];
            #1 chk("R11 bit0 follows tone", {63'd0, dq_o[0]}, {63'd0, t[0]});
        end
        ce_n = 1'b1; oe_n = 1'b1;
        wr(17'h1FFFC, 8'h00);
        #1 chk("R10 ftest_en clear", {63'd0, ftest_en}, 64'd0);
        osc_512 = 1'b1;
        chk_reg("R11 test off", 1);
        osc_512 = 1'b0;

        // R5 read halt freezes copies
        wr(17'h1FFF8, 8'h40 | 8'h19);
        live = 64'h21_06_15_03_08_30_45_20;
        tick();
        #1 chk("R5 no load", {63'd0, load_stb}, 64'd0);
        chk_all("R5 frozen");

        // R6 release, stays until next tick
        wr(17'h1FFF8, 8'h19);
        #1 chk("R6 no load on read release", {63'd0, load_stb}, 64'd0);
        chk_all("R6 held before tick");
        tick();
        chk_all("R6 refreshed on tick");

        // R7 staging and commit
        wr(17'h1FFF8, 8'h80 | 8'h20);
        live = 64'h77_07_07_07_07_07_07_20;
        tick();
        chk_all("R7 no refresh while staging");
        for (int k = 1; k < 8; k++) begin
            wr(17'h1FFF8 + 17'(k), 8'(8'h11 * k));
            #1 chk("R7 no early load", {63'd0, load_stb}, 64'd0);
        end
        wr(17'h1FFF8, 8'h21);
        #1;
        chk("R7 load strobe", {63'd0, load_stb}, 64'd1);
        chk("R7 load values", load_time, exp_load());
        @(negedge clk);
        #1 chk("R7 strobe one cycle", {63'd0, load_stb}, 64'd0);
        chk_all("R7 staged readback");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule